// File: doc/BRIEF.md
# EDID Segment and Offset Replay Tracker

This block sits in front of an I2C-over-AUX transaction engine. It watches every request on its way to the engine and keeps two bytes of state: the EDID segment most recently written to the segment pointer address and the EDID read offset most recently written to the EDID address. Some sinks lose their read pointer between continued (middle-of-transaction) reads. For those reads the block places one or two short write requests ahead of the original, so the sink reloads its segment and offset before it sends the next chunk.

Requests enter on a valid/ready stream. Outputs leave on a second valid/ready stream, toward the engine. The block takes a request only when it is idle and nothing is pending, so `req_ready` low is the only back-pressure it applies. An output, once valid, stays valid with unchanged fields until the engine raises `out_ready`. After the engine takes an injected write, the block waits for a one-cycle `xact_done` pulse from the engine before it presents the next output. The original request is passed on last, and the block does not wait for it to complete. The payload bytes themselves never pass through this block.

Top module: `edid_ptr_replay`

## Requirements
- R1: A request with native=0, read=0 and size non-zero to address 0x30 stores its first data byte as the segment. The same request to address 0x50 stores that byte as the offset. Native requests, size-0 requests and other addresses change neither value.
- R2: Replay is considered only for requests with native=0, read=1, mot=1 and size non-zero. Any other request is forwarded alone and leaves the offset unchanged.
- R3: A qualifying read taken while the offset's low 7 bits are zero (a multiple of 128) gets no injected write, and the offset still advances.
- R4: A qualifying read at an offset that is not a multiple of 128, taken while the segment is non-zero, is preceded first by an injected write of the segment value to address 0x30.
- R5: Such a read is then preceded by an injected write of the offset value, as it was before the advance, to the read's own address. When the segment is zero, this is the only injected write.
- R6: Injected outputs carry out_inject=1, native=0, read=0, mot=0, size=1, out_no_addr=1 and out_no_stop=1. The forwarded original carries its own native, read, mot, address, size and data fields, with out_inject=0, out_no_addr=0 and out_no_stop=0.
- R7: Each qualifying read adds 16 to the 8-bit offset, modulo 256. When the new offset is 0x80, or 0x00 after wrapping from 0xF0, the segment is cleared to zero.
- R8: After an injected write is accepted, no output is presented until an xact_done pulse arrives. An xact_done pulse at any other time has no effect.
- R9: req_ready is high only when the block is idle with no output pending. While out_valid is high and out_ready is low, out_valid and all output fields hold.
- R10: After reset the segment and offset are zero, req_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Block can take a request |
| req_native | input | 1 | 1 = native AUX request, 0 = I2C-over-AUX |
| req_read | input | 1 | 1 = read, 0 = write |
| req_mot | input | 1 | Middle-of-transaction flag |
| req_addr | input | 7 | I2C target address |
| req_size | input | 8 | Byte count of the request |
| req_data | input | 8 | First payload byte |
| xact_done | input | 1 | One-cycle pulse: the engine has completed the injected write |
| out_valid | output | 1 | Outgoing request valid |
| out_ready | input | 1 | Engine takes the outgoing request |
| out_native | output | 1 | Native flag of the outgoing request |
| out_read | output | 1 | Read flag of the outgoing request |
| out_mot | output | 1 | Middle-of-transaction flag of the outgoing request |
| out_addr | output | 7 | Address of the outgoing request |
| out_size | output | 8 | Byte count of the outgoing request |
| out_data | output | 8 | First (or only) data byte of the outgoing request |
| out_no_addr | output | 1 | Engine must skip the address phase |
| out_no_stop | output | 1 | Engine must skip the stop condition |
| out_inject | output | 1 | 1 = injected replay write, 0 = forwarded original |

## Verification
The bench builds the block with its default parameters: a 7-bit address, an 8-bit offset and segment, a 16-byte step and a 128-byte block. With these values a block boundary is eight reads from a captured offset, and an offset loaded as 0xF0 wraps to 0x00 on the next read. Both segment-clearing points, the wrap itself and a non-zero segment across a replay are therefore reached within a short vector table. Directed runs cover output stalls, a missing completion pulse, a stray completion pulse in idle, and reset taken in the middle of a session.

// File: rtl/edid_ptr_pkg.sv
package edid_ptr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_SEG_WAIT,
    ST_OFF,
    ST_OFF_WAIT,
    ST_FWD
  } trk_state_e;

  typedef enum logic [1:0] {
    K_NONE,
    K_SEG,
    K_OFF,
    K_ORIG
  } out_kind_e;

endpackage

// File: rtl/edid_ptr_track.sv
module edid_ptr_track #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 8,
  parameter int STEP   = 16,
  parameter int BLOCK  = 128,
  parameter logic [ADDR_W-1:0] SEG_ADDR  = 7'h30,
  parameter logic [ADDR_W-1:0] EDID_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              native,
  input  logic              read,
  input  logic              mot,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] seg_q,
  output logic [DATA_W-1:0] off_q,
  output logic              qual,
  output logic              aligned
);

  localparam int BLK_BITS = $clog2(BLOCK);
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

  logic              is_wr;
  logic              cap_seg;
  logic              cap_off;
  logic              bump;
  logic [DATA_W-1:0] off_next;
  logic              hits_block;

  always_comb begin
    is_wr      = !native && !read && (size != '0);
    cap_seg    = take && is_wr && (addr == SEG_ADDR);
    cap_off    = take && is_wr && (addr == EDID_ADDR);
    qual       = !native && read && mot && (size != '0);
    aligned    = (off_q[BLK_BITS-1:0] == '0);
    bump       = take && qual;
    off_next   = off_q + STEP_V;
    hits_block = (off_next[BLK_BITS-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0;
      off_q <= '0;
    end else begin
      if (cap_seg)                 seg_q <= data;
      else if (bump && hits_block) seg_q <= '0;
      if (cap_off)                 off_q <= data;
      else if (bump)               off_q <= off_next;
    end
  end

  // R1
  seg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_seg |=> seg_q == $past(data));

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !qual && !cap_off) |=> $stable(off_q));

  // R7
  off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> off_q == $past(off_q) + STEP_V);

  // R7
  seg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> (off_q[BLK_BITS-1:0] != '0) || (seg_q == '0));

endmodule

// File: rtl/edid_ptr_seq.sv
module edid_ptr_seq
  import edid_ptr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      need_seg,
  input  logic      need_off,
  input  logic      out_ready,
  input  logic      done,
  output logic      take,
  output logic      req_ready,
  output logic      out_valid,
  output out_kind_e kind
);

  trk_state_e st_q, st_d;
  logic       fire;

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    take      = req_ready && req_valid;
    out_valid = (st_q == ST_SEG) || (st_q == ST_OFF) || (st_q == ST_FWD);
    fire      = out_valid && out_ready;
    unique case (st_q)
      ST_SEG:  kind = K_SEG;
      ST_OFF:  kind = K_OFF;
      ST_FWD:  kind = K_ORIG;
      default: kind = K_NONE;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (take) st_d = need_seg ? ST_SEG : (need_off ? ST_OFF : ST_FWD);
      ST_SEG:      if (fire) st_d = ST_SEG_WAIT;
      ST_SEG_WAIT: if (done) st_d = ST_OFF;
      ST_OFF:      if (fire) st_d = ST_OFF_WAIT;
      ST_OFF_WAIT: if (done) st_d = ST_FWD;
      ST_FWD:      if (fire) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R8
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SEG_WAIT || st_q == ST_OFF_WAIT) && !done) |=> !out_valid);

  // R9
  hold_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(kind));

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid);

endmodule

// File: rtl/edid_ptr_outsel.sv
module edid_ptr_outsel
  import edid_ptr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 8,
  parameter logic [ADDR_W-1:0] SEG_ADDR = 7'h30
) (
  input  out_kind_e         kind,
  input  logic              h_native,
  input  logic              h_read,
  input  logic              h_mot,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [SIZE_W-1:0] h_size,
  input  logic [DATA_W-1:0] h_data,
  input  logic [DATA_W-1:0] seg_snap,
  input  logic [DATA_W-1:0] off_snap,
  output logic              o_native,
  output logic              o_read,
  output logic              o_mot,
  output logic [ADDR_W-1:0] o_addr,
  output logic [SIZE_W-1:0] o_size,
  output logic [DATA_W-1:0] o_data,
  output logic              o_no_addr,
  output logic              o_no_stop,
  output logic              o_inject
);

  logic inj;

  always_comb begin
    inj       = (kind == K_SEG) || (kind == K_OFF);
    o_inject  = inj;
    o_native  = inj ? 1'b0 : h_native;
    o_read    = inj ? 1'b0 : h_read;
    o_mot     = inj ? 1'b0 : h_mot;
    o_size    = inj ? SIZE_W'(1) : h_size;
    o_no_addr = inj;
    o_no_stop = inj;
    unique case (kind)
      K_SEG: begin
        o_addr = SEG_ADDR;
        o_data = seg_snap;
      end
      K_OFF: begin
        o_addr = h_addr;
        o_data = off_snap;
      end
      default: begin
        o_addr = h_addr;
        o_data = h_data;
      end
    endcase
  end

endmodule

// File: rtl/edid_ptr_replay.sv
module edid_ptr_replay
  import edid_ptr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 8,
  parameter int STEP   = 16,
  parameter int BLOCK  = 128,
  parameter logic [ADDR_W-1:0] SEG_ADDR  = 7'h30,
  parameter logic [ADDR_W-1:0] EDID_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_native,
  input  logic              req_read,
  input  logic              req_mot,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_data,
  input  logic              xact_done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_native,
  output logic              out_read,
  output logic              out_mot,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SIZE_W-1:0] out_size,
  output logic [DATA_W-1:0] out_data,
  output logic              out_no_addr,
  output logic              out_no_stop,
  output logic              out_inject
);

  logic              take;
  logic              qual;
  logic              aligned;
  logic              need_seg;
  logic              need_off;
  logic [DATA_W-1:0] seg_q;
  logic [DATA_W-1:0] off_q;
  out_kind_e         kind;

  logic              h_native, h_read, h_mot;
  logic [ADDR_W-1:0] h_addr;
  logic [SIZE_W-1:0] h_size;
  logic [DATA_W-1:0] h_data;
  logic [DATA_W-1:0] seg_snap, off_snap;

  edid_ptr_track #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .STEP(STEP), .BLOCK(BLOCK), .SEG_ADDR(SEG_ADDR), .EDID_ADDR(EDID_ADDR)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .take(take),
    .native(req_native), .read(req_read), .mot(req_mot),
    .addr(req_addr), .size(req_size), .data(req_data),
    .seg_q(seg_q), .off_q(off_q), .qual(qual), .aligned(aligned)
  );

  always_comb begin
    need_off = qual && !aligned;
    need_seg = need_off && (seg_q != '0);
  end

  edid_ptr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .need_seg(need_seg), .need_off(need_off),
    .out_ready(out_ready), .done(xact_done),
    .take(take), .req_ready(req_ready), .out_valid(out_valid), .kind(kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_native <= 1'b0;
      h_read   <= 1'b0;
      h_mot    <= 1'b0;
      h_addr   <= '0;
      h_size   <= '0;
      h_data   <= '0;
      seg_snap <= '0;
      off_snap <= '0;
    end else if (take) begin
      h_native <= req_native;
      h_read   <= req_read;
      h_mot    <= req_mot;
      h_addr   <= req_addr;
      h_size   <= req_size;
      h_data   <= req_data;
      seg_snap <= seg_q;
      off_snap <= off_q;
    end
  end

  edid_ptr_outsel #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .SEG_ADDR(SEG_ADDR)
  ) u_outsel (
    .kind(kind),
    .h_native(h_native), .h_read(h_read), .h_mot(h_mot),
    .h_addr(h_addr), .h_size(h_size), .h_data(h_data),
    .seg_snap(seg_snap), .off_snap(off_snap),
    .o_native(out_native), .o_read(out_read), .o_mot(out_mot),
    .o_addr(out_addr), .o_size(out_size), .o_data(out_data),
    .o_no_addr(out_no_addr), .o_no_stop(out_no_stop), .o_inject(out_inject)
  );

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data) && $stable(out_addr) && $stable(out_inject));

  // R3
  aligned_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && qual && aligned) |=> out_valid && !out_inject);

  // R4
  seg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inject && kind == K_SEG) |-> out_data != '0);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> req_ready && !out_valid);

endmodule

// File: tb/sim_edid_ptr_replay.sv
module sim_edid_ptr_replay;

  typedef struct packed {
    logic       nat;
    logic       rd;
    logic       mot;
    logic [6:0] addr;
    logic [7:0] size;
    logic [7:0] data;
    logic       eseg;
    logic [7:0] segv;
    logic       eoff;
    logic [7:0] offv;
    logic [7:0] tag;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,7'h50,8'd1, 8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd1}, // R1 offset=00
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd3}, // R3 -> 10
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b1,8'h10, 8'd5}, // R5 -> 20
    '{1'b0,1'b0,1'b1,7'h30,8'd1, 8'h02, 1'b0,8'h00,1'b0,8'h00, 8'd1}, // R1 seg=02
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b1,8'h02,1'b1,8'h20, 8'd4}, // R4 -> 30
    '{1'b0,1'b1,1'b0,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd2}, // R2 mot=0
    '{1'b0,1'b1,1'b1,7'h50,8'd0, 8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd2}, // R2 size=0
    '{1'b1,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd2}, // R2 native
    '{1'b1,1'b0,1'b1,7'h30,8'd1, 8'h07, 1'b0,8'h00,1'b0,8'h00, 8'd1}, // R1 native write
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b1,8'h02,1'b1,8'h30, 8'd2}, // R2 off unchanged -> 40
    '{1'b0,1'b0,1'b1,7'h50,8'd1, 8'h70, 1'b0,8'h00,1'b0,8'h00, 8'd1}, // R1 offset=70
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b1,8'h02,1'b1,8'h70, 8'd7}, // R7 -> 80 seg clear
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd3}, // R3 -> 90
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b1,8'h90, 8'd7}, // R7 seg cleared -> A0
    '{1'b0,1'b0,1'b1,7'h30,8'd1, 8'h01, 1'b0,8'h00,1'b0,8'h00, 8'd1}, // R1 seg=01
    '{1'b0,1'b0,1'b1,7'h50,8'd1, 8'hF0, 1'b0,8'h00,1'b0,8'h00, 8'd1}, // R1 offset=F0
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b1,8'h01,1'b1,8'hF0, 8'd7}, // R7 wrap -> 00
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd3}, // R3 -> 10
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b1,8'h10, 8'd7}, // R7 seg cleared -> 20
    '{1'b0,1'b1,1'b1,7'h54,8'd16,8'h00, 1'b0,8'h00,1'b1,8'h20, 8'd5}, // R5 own address -> 30
    '{1'b0,1'b0,1'b1,7'h51,8'd1, 8'h33, 1'b0,8'h00,1'b0,8'h00, 8'd1}, // R1 other addr
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b1,8'h30, 8'd1}, // R1 unchanged -> 40
    '{1'b0,1'b0,1'b1,7'h50,8'd0, 8'h99, 1'b0,8'h00,1'b0,8'h00, 8'd1}, // R1 size 0
    '{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b1,8'h40, 8'd1}  // R1 unchanged -> 50
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_native = 1'b0, req_read = 1'b0, req_mot = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_size = '0, req_data = '0;
  logic       xact_done = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_native, out_read, out_mot;
  logic [6:0] out_addr;
  logic [7:0] out_size, out_data;
  logic       out_no_addr, out_no_stop, out_inject;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  edid_ptr_replay u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_native(req_native), .req_read(req_read), .req_mot(req_mot),
    .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
    .xact_done(xact_done),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_native(out_native), .out_read(out_read), .out_mot(out_mot),
    .out_addr(out_addr), .out_size(out_size), .out_data(out_data),
    .out_no_addr(out_no_addr), .out_no_stop(out_no_stop), .out_inject(out_inject)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input vec_t v, input bit stall);
    int         n;
    int         guard;
    int         idx;
    bit         fwd_seen;
    logic [6:0] ra [3];
    logic [7:0] rdat [3];
    bit         attr_ok;
    logic [7:0] d0;
    logic       fn, fr, fm, fna, fns;
    logic [6:0] fa;
    logic [7:0] fs, fd;
    string      tg;
    tg = $sformatf("R%0d", v.tag);
    n = 0; guard = 0; fwd_seen = 1'b0; attr_ok = 1'b1;
    fn = 0; fr = 0; fm = 0; fna = 0; fns = 0; fa = '0; fs = '0; fd = '0;
    for (int i = 0; i < 3; i++) begin ra[i] = '0; rdat[i] = '0; end
    @(negedge clk);
    out_ready  = !stall;
    req_native = v.nat; req_read = v.rd; req_mot = v.mot;
    req_addr   = v.addr; req_size = v.size; req_data = v.data;
    req_valid  = 1'b1;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!fwd_seen && guard < 200) begin
      if (out_valid) begin
        if (stall && n == 0) begin
          d0 = out_data;
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid && out_data == d0 && !req_ready, "R9 stalled output holds", out_data, d0);
          end
          out_ready = 1'b1;
        end
        if (out_inject) begin
          if (n < 3) begin ra[n] = out_addr; rdat[n] = out_data; end
          if (out_native || out_read || out_mot || out_size != 8'd1 || !out_no_addr || !out_no_stop)
            attr_ok = 1'b0;
          n++;
          @(negedge clk);
          for (int k = 0; k < 2; k++) begin
            chk(!out_valid, "R8 no output before done", out_valid, 0);
            @(negedge clk);
          end
          xact_done = 1'b1;
          @(negedge clk);
          xact_done = 1'b0;
        end else begin
          fn = out_native; fr = out_read; fm = out_mot; fa = out_addr;
          fs = out_size; fd = out_data; fna = out_no_addr; fns = out_no_stop;
          fwd_seen = 1'b1;
          @(negedge clk);
        end
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(fwd_seen, {tg, " original forwarded"}, fwd_seen, 1);
    chk(n == int'(v.eseg) + int'(v.eoff), {tg, " injected write count"}, n, int'(v.eseg) + int'(v.eoff));
    idx = 0;
    if (v.eseg && n > 0) begin
      chk(ra[0] == 7'h30 && rdat[0] == v.segv, {tg, " R4 segment replay"}, {ra[0], rdat[0]}, {7'h30, v.segv});
      idx = 1;
    end
    if (v.eoff && n > idx) begin
      chk(ra[idx] == v.addr && rdat[idx] == v.offv, {tg, " R5 offset replay"}, {ra[idx], rdat[idx]}, {v.addr, v.offv});
    end
    if (n > 0) chk(attr_ok, "R6 injected attributes", attr_ok, 1);
    chk(fn == v.nat && fr == v.rd && fm == v.mot && fa == v.addr && fs == v.size && fd == v.data
        && !fna && !fns, {tg, " R6 forwarded fields"}, {fn, fr, fm, fa, fs, fd, fna, fns},
        {v.nat, v.rd, v.mot, v.addr, v.size, v.data, 2'b00});
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && !out_valid, "R10 idle after reset", {req_ready, out_valid}, 2'b10);

    for (int i = 0; i < NV; i++) run_req(TBL[i], 1'b0);

    // R8 stray done in idle has no effect
    @(negedge clk); xact_done = 1'b1;
    @(negedge clk); xact_done = 1'b0;
    @(negedge clk);
    chk(!out_valid && req_ready, "R8 stray done ignored", {out_valid, req_ready}, 2'b01);

    // R9 back-pressure during injected and forwarded outputs (offset now 0x50, segment 0)
    run_req('{1'b0,1'b0,1'b1,7'h30,8'd1,8'h04, 1'b0,8'h00,1'b0,8'h00, 8'd9}, 1'b1);
    run_req('{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b1,8'h04,1'b1,8'h50, 8'd9}, 1'b1);

    // R10 reset mid-session clears segment and offset
    run_req('{1'b0,1'b0,1'b1,7'h30,8'd1,8'h05, 1'b0,8'h00,1'b0,8'h00, 8'd1}, 1'b0);
    run_req('{1'b0,1'b0,1'b1,7'h50,8'd1,8'h24, 1'b0,8'h00,1'b0,8'h00, 8'd1}, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !out_valid, "R10 idle after second reset", {req_ready, out_valid}, 2'b10);
    run_req('{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd10}, 1'b0);
    run_req('{1'b0,1'b1,1'b1,7'h50,8'd16,8'h00, 1'b0,8'h00,1'b1,8'h10, 8'd10}, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule